// File: doc/BRIEF.md
# Two-Stage Pipelined Datapath with Backward-Propagated Load Enables

This block is a short arithmetic pipeline. An input word accompanied by a valid strobe is offset by a constant in the first stage and scaled by a constant in the second. The result is then captured in an output register that keeps its value until the next valid result arrives. A one-bit valid token travels beside the data, one stage per clock.

No register in the pipeline loads a value that will never reach the output. The output register loads only when the final-stage valid is high. That hold condition is carried back along the pipeline. The stage-two register is enabled by the token one cycle before it becomes the final-stage valid. The stage-one register is enabled by the input strobe. The enables are plain clock-enable terms that a synthesis flow may map onto gating cells.

An ungated reference pipeline runs beside the gated one and has its own output pins for equivalence comparison. It recomputes both stages on every cycle and keeps its output with a hold multiplexer. One saturating counter per gated register counts the cycles in which that register's load was suppressed.

Top module: `sg_gated_pipe`

## Requirements
- R1: A synchronous active-high reset clears `out_vld`, `dout`, `ref_vld`, `ref_dout` and all three suppressed-load counters to zero on the next clock edge.
- R2: A word `x` presented with `in_vld` high at clock edge k appears on `dout` after edge k+2. The value is `((x + ADD_K) mod 2^(DATA_W+1)) * MUL_K mod 2^OUT_W`, and `out_vld` is high for the cycle following edge k+2 only.
- R3: In every cycle in which no valid token reaches the final stage, `dout` keeps its previous value, and `out_vld` is low.
- R4: The stage-one register loads only at edges where `in_vld` is high. The stage-two register loads only at edges one cycle after such an input. The output register loads only one cycle after a stage-two load. `skip_cnt_1`, `skip_cnt_2` and `skip_cnt_o` each count the non-reset edges at which the matching register did not load.
- R5: On every cycle out of reset, `dout` equals `ref_dout` and `out_vld` equals `ref_vld`.
- R6: Each suppressed-load counter stops at its all-ones value (2^CNT_W − 1) and never wraps.
- R7: Tokens on consecutive cycles are each delivered, in order, on consecutive output cycles, with none lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word is valid this cycle |
| in_data | input | DATA_W | Input word |
| dout | output | DATA_W+1+MUL_W | Held result of the gated pipeline |
| out_vld | output | 1 | `dout` was loaded at the last edge |
| ref_dout | output | DATA_W+1+MUL_W | Held result of the ungated reference pipeline |
| ref_vld | output | 1 | Reference output valid |
| skip_cnt_1 | output | CNT_W | Suppressed loads of the stage-one register |
| skip_cnt_2 | output | CNT_W | Suppressed loads of the stage-two register |
| skip_cnt_o | output | CNT_W | Suppressed loads of the output register |

## Verification
Isolated tokens separated by long idle gaps test whether the output really holds. A design that loads `dout` from a stale or free-running stage would change the held result, or raise `out_vld` during the gap. Back-to-back bursts test the backward-shifted stage-two enable. If that enable were taken from the wrong cycle, adjacent words would merge or repeat at the output, or the gated and reference outputs would disagree. A reset applied while tokens are in flight must drop those tokens. An idle stretch longer than the counter range must leave every counter pinned at all-ones rather than wrapped to a small value.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // Position of each gated register along the pipeline.
  typedef enum logic [1:0] {
    ST_ONE = 2'd0,
    ST_TWO = 2'd1,
    ST_OUT = 2'd2
  } stage_e;

  localparam int N_GATED = 3;

  // First compute stage: offset by a constant.
  function automatic logic [63:0] offset_step(logic [63:0] x, logic [63:0] k);
    return x + k;
  endfunction

  // Second compute stage: scale by a constant.
  function automatic logic [63:0] scale_step(logic [63:0] x, logic [63:0] k);
    return x * k;
  endfunction

endpackage

// File: rtl/sg_en_reg.sv
module sg_en_reg #(
  parameter int W       = 8,
  parameter bit HAS_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // A register with a clock-enable term; reset is optional per instance.
  always_ff @(posedge clk) begin
    if (HAS_RST && rst) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/sg_skip_cnt.sv
module sg_skip_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             skip,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (skip && !at_max) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sg_ref_pipe.sv
module sg_ref_pipe #(
  parameter int DATA_W = 8,
  parameter int ADD_K  = 37,
  parameter int MUL_K  = 5,
  parameter int MUL_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld,
  input  logic [DATA_W-1:0]           in_data,
  output logic [DATA_W+MUL_W:0]       ref_dout,
  output logic                        ref_vld
);

  localparam int D1_W  = DATA_W + 1;
  localparam int OUT_W = D1_W + MUL_W;

  logic [D1_W-1:0]  r_d1;
  logic [OUT_W-1:0] r_d2;
  logic             r_v1;
  logic             r_v2;

  // Both stages recompute every cycle; only the output has a hold path.
  always_ff @(posedge clk) begin
    r_d1 <= D1_W'(sg_pkg::offset_step(64'(in_data), 64'(ADD_K)));
    r_d2 <= OUT_W'(sg_pkg::scale_step(64'(r_d1), 64'(MUL_K)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_v1     <= 1'b0;
      r_v2     <= 1'b0;
      ref_vld  <= 1'b0;
      ref_dout <= '0;
    end else begin
      r_v1     <= in_vld;
      r_v2     <= r_v1;
      ref_vld  <= r_v2;
      ref_dout <= r_v2 ? r_d2 : ref_dout;
    end
  end

endmodule

// File: rtl/sg_gated_pipe.sv
module sg_gated_pipe #(
  parameter int DATA_W = 8,
  parameter int ADD_K  = 37,
  parameter int MUL_K  = 5,
  parameter int MUL_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_vld,
  input  logic [DATA_W-1:0]     in_data,
  output logic [DATA_W+MUL_W:0] dout,
  output logic                  out_vld,
  output logic [DATA_W+MUL_W:0] ref_dout,
  output logic                  ref_vld,
  output logic [CNT_W-1:0]      skip_cnt_1,
  output logic [CNT_W-1:0]      skip_cnt_2,
  output logic [CNT_W-1:0]      skip_cnt_o
);

  import sg_pkg::*;

  localparam int D1_W  = DATA_W + 1;
  localparam int OUT_W = D1_W + MUL_W;

  // Valid token chain: stage-one valid, final-stage valid, output valid.
  logic [2:0] vchain_d;
  logic [2:0] vchain_q;
  logic       vld_1;
  logic       vld_2;

  assign vchain_d = {vchain_q[1], vchain_q[0], in_vld};
  assign vld_1    = vchain_q[0];
  assign vld_2    = vchain_q[1];
  assign out_vld  = vchain_q[2];

  for (genvar g = 0; g < 3; g++) begin : g_vchain
    sg_en_reg #(.W(1), .HAS_RST(1'b1)) u_v (
      .clk (clk),
      .rst (rst),
      .en  (1'b1),
      .d   (vchain_d[g]),
      .q   (vchain_q[g])
    );
  end

  // Load enables. The output hold condition is the final-stage valid.
  // Shifted back one cycle it is vld_1 (its source register); shifted back
  // two cycles it is the input strobe itself.
  logic [N_GATED-1:0] load;
  logic               load_1;
  logic               load_2;
  logic               load_o;

  assign load_o = vld_2;
  assign load_2 = vld_1;
  assign load_1 = in_vld;

  assign load[ST_ONE] = load_1;
  assign load[ST_TWO] = load_2;
  assign load[ST_OUT] = load_o;

  // Stage computations.
  logic [D1_W-1:0]  s1_next;
  logic [D1_W-1:0]  d_1;
  logic [OUT_W-1:0] s2_next;
  logic [OUT_W-1:0] d_2;

  assign s1_next = D1_W'(offset_step(64'(in_data), 64'(ADD_K)));
  assign s2_next = OUT_W'(scale_step(64'(d_1), 64'(MUL_K)));

  sg_en_reg #(.W(D1_W), .HAS_RST(1'b0)) u_d1 (
    .clk (clk),
    .rst (rst),
    .en  (load_1),
    .d   (s1_next),
    .q   (d_1)
  );

  sg_en_reg #(.W(OUT_W), .HAS_RST(1'b0)) u_d2 (
    .clk (clk),
    .rst (rst),
    .en  (load_2),
    .d   (d_2_src(s2_next)),
    .q   (d_2)
  );

  sg_en_reg #(.W(OUT_W), .HAS_RST(1'b1)) u_dout (
    .clk (clk),
    .rst (rst),
    .en  (load_o),
    .d   (d_2),
    .q   (dout)
  );

  function automatic logic [OUT_W-1:0] d_2_src(logic [OUT_W-1:0] v);
    return v;
  endfunction

  // Suppressed-load counters, one per gated register.
  logic [N_GATED-1:0]            skip_ev;
  logic [N_GATED-1:0][CNT_W-1:0] skip_cnt;

  for (genvar s = 0; s < N_GATED; s++) begin : g_skip
    assign skip_ev[s] = !load[s];
    sg_skip_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .skip (skip_ev[s]),
      .cnt  (skip_cnt[s])
    );
  end

  assign skip_cnt_1 = skip_cnt[ST_ONE];
  assign skip_cnt_2 = skip_cnt[ST_TWO];
  assign skip_cnt_o = skip_cnt[ST_OUT];

  // Ungated reference copy for equivalence comparison.
  sg_ref_pipe #(
    .DATA_W (DATA_W),
    .ADD_K  (ADD_K),
    .MUL_K  (MUL_K),
    .MUL_W  (MUL_W)
  ) u_ref (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .ref_dout (ref_dout),
    .ref_vld  (ref_vld)
  );

endmodule

// File: rtl/sg_gated_pipe_chk.sv
module sg_gated_pipe_chk #(
  parameter int D1_W  = 9,
  parameter int OUT_W = 13,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             load_1,
  input logic             load_2,
  input logic             load_o,
  input logic             vld_2,
  input logic [D1_W-1:0]  d_1,
  input logic [OUT_W-1:0] d_2,
  input logic [OUT_W-1:0] dout,
  input logic             out_vld,
  input logic [OUT_W-1:0] ref_dout,
  input logic             ref_vld,
  input logic [CNT_W-1:0] skip_cnt_1,
  input logic [CNT_W-1:0] skip_cnt_2,
  input logic [CNT_W-1:0] skip_cnt_o
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && dout == '0 && !ref_vld && ref_dout == '0 &&
             skip_cnt_1 == '0 && skip_cnt_2 == '0 && skip_cnt_o == '0));

  // R2
  out_vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    vld_2 |=> out_vld);

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld_2 |=> ($stable(dout) && !out_vld));

  // R4
  d1_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !load_1 |=> $stable(d_1));

  // R4
  d2_closed_chk: assert property (@(posedge clk) disable iff (rst)
    !load_2 |=> $stable(d_2));

  // R4
  d2_back_chk: assert property (@(posedge clk) disable iff (rst)
    load_2 |-> $past(load_1));

  // R4
  dout_back_chk: assert property (@(posedge clk) disable iff (rst)
    load_o |-> $past(load_2));

  // R5
  equiv_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld == ref_vld) && (dout == ref_dout));

  // R6
  skip1_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_1 && skip_cnt_1 != CMAX) |=> skip_cnt_1 == $past(skip_cnt_1) + 1'b1);

  // R6
  skip_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (skip_cnt_o == CMAX) |=> (skip_cnt_o == CMAX));

  // R4
  skip2_hold_chk: assert property (@(posedge clk) disable iff (rst)
    load_2 |=> $stable(skip_cnt_2));

endmodule

bind sg_gated_pipe sg_gated_pipe_chk #(
  .D1_W  (D1_W),
  .OUT_W (OUT_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .load_1     (load_1),
  .load_2     (load_2),
  .load_o     (load_o),
  .vld_2      (vld_2),
  .d_1        (d_1),
  .d_2        (d_2),
  .dout       (dout),
  .out_vld    (out_vld),
  .ref_dout   (ref_dout),
  .ref_vld    (ref_vld),
  .skip_cnt_1 (skip_cnt_1),
  .skip_cnt_2 (skip_cnt_2),
  .skip_cnt_o (skip_cnt_o)
);

// File: tb/sg_gated_pipe_tb_top.sv
module sg_gated_pipe_tb_top;

  localparam int DATA_W = 8;
  localparam int ADD_K  = 37;
  localparam int MUL_K  = 5;
  localparam int MUL_W  = 4;
  localparam int CNT_W  = 8;
  localparam int OUT_W  = DATA_W + 1 + MUL_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_vld = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [OUT_W-1:0]  dout;
  logic              out_vld;
  logic [OUT_W-1:0]  ref_dout;
  logic              ref_vld;
  logic [CNT_W-1:0]  skip_cnt_1;
  logic [CNT_W-1:0]  skip_cnt_2;
  logic [CNT_W-1:0]  skip_cnt_o;

  always #10 clk = ~clk;

  sg_gated_pipe #(
    .DATA_W (DATA_W), .ADD_K (ADD_K), .MUL_K (MUL_K),
    .MUL_W (MUL_W), .CNT_W (CNT_W)
  ) dut_i (
    .clk (clk), .rst (rst), .in_vld (in_vld), .in_data (in_data),
    .dout (dout), .out_vld (out_vld), .ref_dout (ref_dout), .ref_vld (ref_vld),
    .skip_cnt_1 (skip_cnt_1), .skip_cnt_2 (skip_cnt_2), .skip_cnt_o (skip_cnt_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit in_burst = 0;

  // Behavioural model: a queue of the last two accepted tokens and plain integers.
  bit v_q[$];
  int d_q[$];
  int exp_dout = 0;
  bit exp_ov = 0;
  int exp_c1 = 0, exp_c2 = 0, exp_co = 0;

  function automatic int expect_val(int x);
    int t;
    t = (x + ADD_K) % (1 << (DATA_W + 1));
    return (t * MUL_K) % (1 << OUT_W);
  endfunction

  function automatic int sat_inc(int c);
    return (c < CMAX) ? c + 1 : c;
  endfunction

  initial begin
    v_q = '{0, 0};
    d_q = '{0, 0};
  end

  always @(posedge clk) begin
    if (rst) begin
      v_q = '{0, 0};
      d_q = '{0, 0};
      exp_dout = 0; exp_ov = 0;
      exp_c1 = 0; exp_c2 = 0; exp_co = 0;
    end else begin
      // v_q[0] is the stage-one token, v_q[1] the final-stage token
      if (!in_vld) exp_c1 = sat_inc(exp_c1);
      if (!v_q[0]) exp_c2 = sat_inc(exp_c2);
      if (!v_q[1]) exp_co = sat_inc(exp_co);
      exp_ov = v_q[1];
      if (v_q[1]) exp_dout = expect_val(d_q[1]);
      void'(v_q.pop_back()); void'(d_q.pop_back());
      v_q.push_front(in_vld); d_q.push_front(int'(in_data));
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", "out_vld", int'(out_vld), int'(exp_ov));
    if (in_burst)
      chk("R7", "dout", int'(dout), exp_dout);
    else if (exp_ov)
      chk("R2", "dout", int'(dout), exp_dout);
    else
      chk("R3", "dout held", int'(dout), exp_dout);
    chk("R5", "ref_dout vs dout", int'(ref_dout), int'(dout));
    chk("R5", "ref_vld vs out_vld", int'(ref_vld), int'(out_vld));
    chk("R4", "skip_cnt_1", int'(skip_cnt_1), exp_c1);
    chk("R4", "skip_cnt_2", int'(skip_cnt_2), exp_c2);
    chk("R6", "skip_cnt_o", int'(skip_cnt_o), exp_co);
  endtask

  // One clock: check the outputs of the last edge, then drive the next inputs.
  task automatic step(bit v, int d);
    @(negedge clk);
    if (!rst) compare_all();
    in_vld  = v;
    in_data = DATA_W'(d);
  endtask

  task automatic check_reset_state();
    chk("R1", "out_vld", int'(out_vld), 0);
    chk("R1", "dout", int'(dout), 0);
    chk("R1", "ref_vld", int'(ref_vld), 0);
    chk("R1", "skip_cnt_1", int'(skip_cnt_1), 0);
    chk("R1", "skip_cnt_2", int'(skip_cnt_2), 0);
    chk("R1", "skip_cnt_o", int'(skip_cnt_o), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();  // R1
    rst = 1'b0;

    // Isolated tokens with long idle gaps (R2, R3)
    for (int i = 0; i < 6; i++) begin
      step(1, 40 * i + 3);
      for (int j = 0; j < 12 + i * 5; j++) step(0, $urandom_range(0, 255));
    end

    // Boundary input values (R2)
    step(1, 255); step(0, 0); step(0, 0); step(0, 0); step(0, 0);
    step(1, 0);   step(0, 0); step(0, 0); step(0, 0); step(0, 0);

    // Back-to-back burst (R7)
    in_burst = 1;
    for (int i = 0; i < 24; i++) step(1, (i * 37 + 11) % 256);
    for (int i = 0; i < 4; i++) step(0, 0);
    in_burst = 0;

    // Random valid pattern with bursts and gaps
    for (int i = 0; i < 600; i++) step(($urandom % 3) != 0, $urandom_range(0, 255));

    // Reset with tokens in flight (R1)
    step(1, 17); step(1, 99);
    @(negedge clk);
    compare_all();
    rst = 1'b1;
    in_vld = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    for (int i = 0; i < 6; i++) step(0, 0);

    // Long idle stretch: counters must pin at all-ones (R6)
    step(1, 200);
    for (int i = 0; i < 300; i++) step(0, $urandom_range(0, 255));
    chk("R6", "skip_cnt_1 saturated", int'(skip_cnt_1), CMAX);
    chk("R6", "skip_cnt_2 saturated", int'(skip_cnt_2), CMAX);
    chk("R6", "skip_cnt_o saturated", int'(skip_cnt_o), CMAX);
    chk("R3", "dout held after idle", int'(dout), expect_val(200));

    // Final random run
    for (int i = 0; i < 400; i++) step(($urandom % 2) != 0, $urandom_range(0, 255));
    for (int i = 0; i < 5; i++) step(0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule